// File: doc/BRIEF.md
# Oscillator Control Register with Interlocks

This block is one 32-bit control and status word for two clock sources: an on-chip RC oscillator and an off-chip crystal oscillator. Software turns each source on or off, selects whether the crystal path is bypassed by an external clock, and writes a 5-bit trim value. An 8-bit calibration value is captured from an input port while reset is held. Each source has a ready flag that tracks its enable. The flag rises after a fixed number of that source's ticks once the source is enabled. It falls six ticks after the source is disabled.

Hardware events can override software. Entering a low-power stop state switches the crystal source off. Leaving that state switches the RC source on. A crystal failure while the crystal drives the system clock also switches the RC source on. Software cannot switch off the source that currently drives the system clock. The bypass bit can only be changed while the crystal source is off.

The block also drives an effective trim word, which is calibration plus trim, saturated at 255. The register port is a plain write strobe with byte enables and an always-valid read word. It has no handshake, so there is no back-pressure. Every write is accepted in the cycle its strobe is high. Oscillator ticks arrive as single-cycle enable strobes in the register clock domain.

Top module: `osc_ctrl_reg`

## Requirements
- R1: While reset is held and at release, the outputs and register word take these values. RC enable is 1, crystal enable is 0, bypass is 0, trim is 16, and both ready flags are 0. The calibration field holds the value of `cal_init` present during reset.
- R2: The read word has this layout. Bit 0 is the RC enable and bit 1 the RC ready flag. Bit 2 reads 0. Bits 7:3 hold the trim and bits 15:8 the calibration. Bit 16 is the crystal enable, bit 17 the crystal ready flag and bit 18 the bypass bit. Bits 31:19 read 0. Byte enable 0 writes the RC enable and the trim. Byte enable 2 writes the crystal enable and the bypass bit. Byte enables 1 and 3 change nothing, and the ready and calibration fields are read-only.
- R3: A write to the bypass bit takes effect only if the crystal enable was 0 before the write. This includes a write that turns the crystal on in the same cycle. Otherwise the bypass bit keeps its value.
- R4: A ready flag rises on the edge that samples the START_TICKS-th tick of its own oscillator while its enable is 1. Clearing the enable before that point restarts the count from zero.
- R5: After an enable is cleared, its ready flag stays 1 through five ticks and falls on the edge that samples the sixth. Setting the enable again before that cancels the fall.
- R6: A pulse on `lp_enter` clears the crystal enable on the next edge. This wins over software writes and over the clock-source interlock.
- R7: While `sysclk_uses_ext` is 1, a software write cannot clear a set crystal enable.
- R8: A pulse on `lp_exit` sets the RC enable. So does a pulse on `ext_fail` while `sysclk_uses_ext` is 1. A pulse on `ext_fail` while `sysclk_uses_ext` is 0 has no effect.
- R9: While `sysclk_uses_int` is 1, a software write cannot clear a set RC enable.
- R10: `eff_trim` equals calibration plus trim when the sum is at most 255, and 255 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Write strobe |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register word |
| cal_init | input | 8 | Calibration value sampled during reset |
| int_tick | input | 1 | One-cycle strobe per RC oscillator cycle |
| ext_tick | input | 1 | One-cycle strobe per crystal oscillator cycle |
| lp_enter | input | 1 | Pulse: entering stop/standby state |
| lp_exit | input | 1 | Pulse: leaving stop/standby state |
| ext_fail | input | 1 | Pulse: crystal failure detected |
| sysclk_uses_int | input | 1 | RC source drives system clock (directly or via PLL) |
| sysclk_uses_ext | input | 1 | Crystal source drives system clock (directly or via PLL) |
| int_en | output | 1 | RC oscillator enable |
| ext_en | output | 1 | Crystal oscillator enable |
| ext_byp | output | 1 | Crystal bypass select |
| eff_trim | output | 8 | Saturated calibration plus trim |

## Verification
The hardest situations are the edges of the ready-flag countdowns. The flag must fall on exactly the sixth tick after a clear, and a re-enable in the middle of a countdown must cancel the fall. An abandoned startup must also leave no residue in the count. To reach these, the bench steps each oscillator's tick strobe by exact counts and checks the flag just before and just after the boundary tick. It toggles the enable part-way through both the startup and the shutdown count. The overrides are driven while the conflicting interlock input is active, so each check also shows which source takes priority.

// File: rtl/osc_ctrl_pkg.sv
package osc_ctrl_pkg;
  localparam int CAL_W    = 8;
  localparam int TRIM_W   = 5;
  localparam int TRIM_RST = 16;
  localparam int OSC_N    = 2;
  localparam int OSC_INT  = 0;
  localparam int OSC_EXT  = 1;

  localparam int POS_INT_EN  = 0;
  localparam int POS_INT_RDY = 1;
  localparam int POS_TRIM    = 3;
  localparam int POS_CAL     = 8;
  localparam int POS_EXT_EN  = 16;
  localparam int POS_EXT_RDY = 17;
  localparam int POS_BYP     = 18;

  typedef struct packed {
    logic              byp;
    logic              ext_en;
    logic              int_en;
    logic [TRIM_W-1:0] trim;
  } osc_sw_t;
endpackage

// File: rtl/osc_ready_track.sv
module osc_ready_track #(
  parameter int START_TICKS = 4,
  parameter int STOP_TICKS  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  output logic rdy
);
  localparam int MAXC = (START_TICKS > STOP_TICKS) ? START_TICKS : STOP_TICKS;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = rdy ? CW'(STOP_TICKS - 1) : CW'(START_TICKS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy <= 1'b0;
      cnt <= '0;
    end else if (en == rdy) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == limit) begin
        rdy <= en;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_rdy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rdy && (en || !tick) |=> rdy);
  assert_rdy_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy && (!en || !tick) |=> !rdy);
  assert_fall_after_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> !$past(en));
endmodule

// File: rtl/osc_trim_sum.sv
module osc_trim_sum #(
  parameter int CAL_W  = 8,
  parameter int TRIM_W = 5
) (
  input  logic [CAL_W-1:0]  cal,
  input  logic [TRIM_W-1:0] trim,
  output logic [CAL_W-1:0]  eff
);
  logic [CAL_W:0] sum;

  assign sum = {1'b0, cal} + (CAL_W+1)'(trim);
  assign eff = sum[CAL_W] ? {CAL_W{1'b1}} : sum[CAL_W-1:0];

  always_comb begin
    assert_trim_floor_R10: assert (eff >= cal && eff >= CAL_W'(trim));
  end
endmodule

// File: rtl/osc_ctrl_reg.sv
module osc_ctrl_reg
  import osc_ctrl_pkg::*;
#(
  parameter int START_TICKS = 4,
  parameter int STOP_TICKS  = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_be,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [7:0]  cal_init,
  input  logic        int_tick,
  input  logic        ext_tick,
  input  logic        lp_enter,
  input  logic        lp_exit,
  input  logic        ext_fail,
  input  logic        sysclk_uses_int,
  input  logic        sysclk_uses_ext,
  output logic        int_en,
  output logic        ext_en,
  output logic        ext_byp,
  output logic [7:0]  eff_trim
);
  osc_sw_t          sw_q, sw_d;
  logic [CAL_W-1:0] cal_q;
  logic [OSC_N-1:0] en_v, tick_v, rdy_v;
  logic             wr_lo, wr_hi, force_int;
  logic             unused_ok;

  assign wr_lo     = reg_we & reg_be[0];
  assign wr_hi     = reg_we & reg_be[2];
  assign force_int = lp_exit | (ext_fail & sysclk_uses_ext);

  always_comb begin
    sw_d = sw_q;
    if (wr_lo) begin
      sw_d.int_en = reg_wdata[POS_INT_EN] | (sw_q.int_en & sysclk_uses_int);
      sw_d.trim   = reg_wdata[POS_TRIM +: TRIM_W];
    end
    if (wr_hi) begin
      sw_d.ext_en = reg_wdata[POS_EXT_EN] | (sw_q.ext_en & sysclk_uses_ext);
      if (!sw_q.ext_en) sw_d.byp = reg_wdata[POS_BYP];
    end
    if (force_int) sw_d.int_en = 1'b1;
    if (lp_enter)  sw_d.ext_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q.byp    <= 1'b0;
      sw_q.ext_en <= 1'b0;
      sw_q.int_en <= 1'b1;
      sw_q.trim   <= TRIM_W'(TRIM_RST);
    end else begin
      sw_q <= sw_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cal_q <= cal_init;
  end

  assign en_v[OSC_INT]   = sw_q.int_en;
  assign en_v[OSC_EXT]   = sw_q.ext_en;
  assign tick_v[OSC_INT] = int_tick;
  assign tick_v[OSC_EXT] = ext_tick;

  generate
    for (genvar g = 0; g < OSC_N; g++) begin : g_track
      osc_ready_track #(
        .START_TICKS(START_TICKS),
        .STOP_TICKS (STOP_TICKS)
      ) u_track (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en_v[g]),
        .tick (tick_v[g]),
        .rdy  (rdy_v[g])
      );
    end
  endgenerate

  osc_trim_sum #(.CAL_W(CAL_W), .TRIM_W(TRIM_W)) u_trim (
    .cal (cal_q),
    .trim(sw_q.trim),
    .eff (eff_trim)
  );

  always_comb begin
    reg_rdata = '0;
    reg_rdata[POS_INT_EN]            = sw_q.int_en;
    reg_rdata[POS_INT_RDY]           = rdy_v[OSC_INT];
    reg_rdata[POS_TRIM +: TRIM_W]    = sw_q.trim;
    reg_rdata[POS_CAL +: CAL_W]      = cal_q;
    reg_rdata[POS_EXT_EN]            = sw_q.ext_en;
    reg_rdata[POS_EXT_RDY]           = rdy_v[OSC_EXT];
    reg_rdata[POS_BYP]               = sw_q.byp;
  end

  assign int_en  = sw_q.int_en;
  assign ext_en  = sw_q.ext_en;
  assign ext_byp = sw_q.byp;

  assign unused_ok = ^{reg_be[3], reg_be[1], reg_wdata[31:19], reg_wdata[17],
                       reg_wdata[15:8], reg_wdata[2:1]};

  assert_byp_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_q.ext_en |=> sw_q.byp == $past(sw_q.byp));
  assert_lp_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lp_enter |=> !ext_en);
  assert_ext_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_en && sysclk_uses_ext && !lp_enter |=> ext_en);
  assert_int_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lp_exit || (ext_fail && sysclk_uses_ext) |=> int_en);
  assert_int_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int_en && sysclk_uses_int |=> int_en);
endmodule

// File: tb/osc_ctrl_reg_test.sv
module osc_ctrl_reg_test;
  localparam logic [7:0] CAL = 8'hF5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        int_tick = 1'b0, ext_tick = 1'b0;
  logic        lp_enter = 1'b0, lp_exit = 1'b0, ext_fail = 1'b0;
  logic        sysclk_uses_int = 1'b0, sysclk_uses_ext = 1'b0;
  logic        int_en, ext_en, ext_byp;
  logic [7:0]  eff_trim;

  always #5 clk = ~clk;

  osc_ctrl_reg uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cal_init(CAL),
    .int_tick(int_tick), .ext_tick(ext_tick), .lp_enter(lp_enter),
    .lp_exit(lp_exit), .ext_fail(ext_fail), .sysclk_uses_int(sysclk_uses_int),
    .sysclk_uses_ext(sysclk_uses_ext), .int_en(int_en), .ext_en(ext_en),
    .ext_byp(ext_byp), .eff_trim(eff_trim)
  );

  typedef struct {
    bit          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // shadow state from the requirements
  logic s_int_en = 1'b1, s_int_rdy = 1'b0, s_ext_en = 1'b0, s_ext_rdy = 1'b0, s_byp = 1'b0;
  logic [4:0] s_trim = 5'd16;

  function automatic logic [31:0] exp_word();
    return {13'b0, s_byp, s_ext_rdy, s_ext_en, CAL, s_trim, 1'b0, s_int_rdy, s_int_en};
  endfunction

  function automatic logic [7:0] exp_eff();
    int sum = int'(CAL) + int'(s_trim);
    return (sum > 255) ? 8'hFF : 8'(sum);
  endfunction

  task automatic check_now(string tag);
    item_t a, b;
    a.kind = 1'b0; a.exp = exp_word(); a.tag = tag;
    b.kind = 1'b1; b.exp = {20'b0, exp_eff(), 1'b0, s_byp, s_ext_en, s_int_en}; b.tag = tag;
    sb_q.push_back(a);
    sb_q.push_back(b);
    #3;
  endtask

  // monitor: compares away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = it.kind ? {20'b0, eff_trim, 1'b0, ext_byp, ext_en, int_en} : reg_rdata;
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s %s actual=%h expected=%h", it.tag,
                   it.kind ? "outputs" : "rdata", act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_be = '0; reg_wdata = '0;
  endtask

  task automatic ticks(input bit ext, input int n);
    @(negedge clk);
    if (ext) ext_tick = 1'b1; else int_tick = 1'b1;
    repeat (n) @(negedge clk);
    ext_tick = 1'b0; int_tick = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: lp_enter = 1'b1;
      1: lp_exit  = 1'b1;
      default: ext_fail = 1'b1;
    endcase
    @(negedge clk);
    lp_enter = 1'b0; lp_exit = 1'b0; ext_fail = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_now("R1 reset state, R10 saturated at reset");

    ticks(0, 3);
    check_now("R4 int ready low after 3 ticks");
    ticks(0, 1);
    s_int_rdy = 1'b1;
    check_now("R4 int ready after 4th tick");

    wr(4'b0001, 32'h0001_0011);
    s_trim = 5'd2;
    check_now("R2 lane0 write, lane2 bit ignored; R10 sum 247");

    wr(4'b1010, 32'hFFFF_FFFF);
    check_now("R2 lanes 1 and 3 ignored");

    wr(4'b0100, 32'h0005_0000);
    s_ext_en = 1'b1; s_byp = 1'b1;
    check_now("R3 bypass written with enable while off");

    wr(4'b0100, 32'h0001_0000);
    check_now("R3 bypass locked while on");

    ticks(1, 4);
    s_ext_rdy = 1'b1;
    check_now("R4 ext ready after 4 ticks");

    sysclk_uses_ext = 1'b1;
    wr(4'b0100, 32'h0004_0000);
    check_now("R7 ext enable kept while driving sysclk");

    wr(4'b0001, 32'h0000_0010);
    s_int_en = 1'b0;
    check_now("R9 int enable clearable when not sysclk");
    ticks(0, 5);
    check_now("R5 int ready held through 5 ticks");
    ticks(0, 1);
    s_int_rdy = 1'b0;
    check_now("R5 int ready falls on 6th tick");

    sysclk_uses_ext = 1'b0;
    pulse(2);
    check_now("R8 ext_fail ignored when ext not sysclk");
    sysclk_uses_ext = 1'b1;
    pulse(2);
    s_int_en = 1'b1;
    check_now("R8 ext_fail forces int enable");

    sysclk_uses_int = 1'b1;
    wr(4'b0001, 32'h0000_0010);
    check_now("R9 int enable kept while driving sysclk");
    sysclk_uses_int = 1'b0;

    pulse(0);
    s_ext_en = 1'b0;
    check_now("R6 lp_enter clears ext enable despite interlock");
    sysclk_uses_ext = 1'b0;
    ticks(1, 5);
    check_now("R5 ext ready held through 5 ticks");
    ticks(1, 1);
    s_ext_rdy = 1'b0;
    check_now("R5 ext ready falls on 6th tick");

    wr(4'b0001, 32'h0000_0010);
    s_int_en = 1'b0;
    pulse(1);
    s_int_en = 1'b1;
    check_now("R8 lp_exit forces int enable");

    wr(4'b0100, 32'h0001_0000);
    s_ext_en = 1'b1; s_byp = 1'b0;
    check_now("R3 bypass cleared while off");
    ticks(1, 3);
    wr(4'b0100, 32'h0000_0000);
    s_ext_en = 1'b0;
    wr(4'b0100, 32'h0001_0000);
    s_ext_en = 1'b1;
    ticks(1, 3);
    check_now("R4 aborted startup restarts count");
    ticks(1, 1);
    s_ext_rdy = 1'b1;
    check_now("R4 ext ready after full restarted count");

    wr(4'b0100, 32'h0000_0000);
    s_ext_en = 1'b0;
    ticks(1, 3);
    wr(4'b0100, 32'h0001_0000);
    s_ext_en = 1'b1;
    ticks(1, 5);
    check_now("R5 re-enable cancels ready fall");

    wr(4'b0001, 32'h0000_0051);
    s_trim = 5'd10;
    check_now("R10 sum exactly 255");
    wr(4'b0001, 32'h0000_0059);
    s_trim = 5'd11;
    check_now("R10 sum 256 saturates");

    @(negedge clk);
    #4;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule